// File: doc/BRIEF.md
# SPI Flash Command Framer

This block runs one complete command exchange with a serial NOR flash over a four-wire SPI link. A request names the command byte and says whether an address follows. When one does, the request gives how many of its bytes, from one to four, are sent. It also gives the length of a data phase, which may be zero, and whether that phase reads or writes. The framer lowers chip select and clocks the command byte out, then the address bytes, then the data. Write bytes are pulled from a byte stream. Read bytes are captured from the flash into a second byte stream. Chip select then returns high.

The link runs in clock mode 0 on one data line in each direction. The serial clock idles low. The framer updates the outgoing line on the falling edge and samples the incoming line on the rising edge. The serial clock is derived from the system clock by a parameterised half-period divider. When a request finishes, a one-cycle acknowledge is returned. A request that asks for an address but gives a byte count outside 1..4 is refused with an error pulse, and no frame is started. Opcode-only commands such as write enable, status reads that carry no address, page programs and erases with no data are all expressed through the same request fields.

Top module: `spi_frame_engine`

## Requirements
- R1: In every frame, while chip select is low, the command byte goes out first, then the address bytes, then the data phase. Each byte is sent MSB first on mosi_o.
- R2: When req_has_addr_i=1, the address bytes sent are the low req_addr_bytes_i bytes of req_addr_i. The most significant of those bytes is sent first. For example, 0x12345678 with 3 bytes sends 0x34, 0x56, 0x78.
- R3: A request with req_has_addr_i=1 and req_addr_bytes_i equal to 0 or greater than 4 raises cfg_err_o for exactly one cycle. Chip select stays high and no acknowledge follows.
- R4: A read (req_read_i=1) with count N clocks exactly N bytes in from miso_i, MSB first, while sending 0x00. The bytes appear on rdata_o/rvalid_o in order. rdata_o is held while rvalid_o=1 and rready_i=0.
- R5: A write with count 0 ends the frame right after the last address byte, so the frame holds 1 + req_addr_bytes_i bytes.
- R6: A request with req_has_addr_i=0 and count 0 is a one-byte frame holding only the command byte.
- R7: A read with req_has_addr_i=0 starts its data phase directly after the command byte.
- R8: Between two frames, chip select stays high for at least 4*HALF_DIV clk_i cycles, which is two serial clock periods.
- R9: sclk_o is low whenever cs_no is high. mosi_o changes only while sclk_o is low.
- R10: ack_o is a single-cycle pulse that occurs only while cs_no is high, once per accepted request.
- R11: A write with count N takes exactly N bytes from wdata_i, each on a cycle with wvalid_i=1 and wready_o=1, and sends them in stream order. If wvalid_i is low, the serial clock stays low with chip select held, and the frame goes on when data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request; held until ack_o or cfg_err_o |
| req_opcode_i | input | 8 | Command byte |
| req_has_addr_i | input | 1 | An address phase follows the command |
| req_addr_bytes_i | input | 3 | Address length in bytes, legal 1..4 |
| req_addr_i | input | 32 | Address, big-endian, low bytes used |
| req_read_i | input | 1 | Data phase direction: 1 read, 0 write |
| req_count_i | input | CNT_W | Data phase length in bytes |
| ack_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | One-cycle pulse for a refused request |
| wdata_i | input | 8 | Write data byte |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Framer takes the write byte |
| rdata_o | output | 8 | Read data byte |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Consumer takes the read byte |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |
| cs_no | output | 1 | Chip select, active low |

## Verification
The hardest case to reach is a data phase that stalls in the middle of a frame. Either the write stream runs dry between bytes, or the previous read byte has not been taken when the next byte would start. The framer must then hold the serial clock low with chip select asserted and lose or repeat no bit. The stimulus gates wvalid_i and rready_i with a periodic pattern that drops them for three of every five cycles during selected multi-byte transfers. A behavioural flash model on the pins answers every frame with a position-dependent byte pattern, so any slip or repeat in a stalled read shows up in the returned stream.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int unsigned ADDR_MAX_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_GAP,
    ST_ACK
  } frame_st_e;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  logic       busy_q, sclk_q;
  logic [2:0] bit_q;
  logic [7:0] tx_q, rx_q;

  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = busy_q && tick_i && sclk_q && (bit_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= tx_i;
    end else if (busy_q && tick_i) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;                      // rising: sample
        rx_q   <= {rx_q[6:0], miso_i};
      end else begin
        sclk_q <= 1'b0;                      // falling: shift
        if (bit_q == 3'd7) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 3'd1;
          tx_q  <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assert_start_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned GAP_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [7:0]       req_opcode_i,
  input  logic             req_has_addr_i,
  input  logic [2:0]       req_addr_bytes_i,
  input  logic [31:0]      req_addr_i,
  input  logic             req_read_i,
  input  logic [CNT_W-1:0] req_count_i,
  output logic             ack_o,
  output logic             cfg_err_o,
  input  logic [7:0]       wdata_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  input  logic             rready_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [7:0]       rx_i,
  output logic             start_o,
  output logic [7:0]       tx_o,
  output logic             cs_no
);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);

  frame_st_e        st_q;
  logic [7:0]       opc_q, rdata_q;
  logic [31:0]      addr_q;
  logic             has_addr_q, read_q, issued_q, cs_q, cfg_err_q, rvalid_q;
  logic [1:0]       idx_q;
  logic [CNT_W-1:0] rem_q;
  logic [GW-1:0]    gap_q;
  logic             bad_cfg, in_byte_st, byte_ok;

  assign bad_cfg = req_has_addr_i &&
                   ((req_addr_bytes_i == 3'd0) || (req_addr_bytes_i > 3'(ADDR_MAX_BYTES)));
  assign in_byte_st = (st_q == ST_OPC) || (st_q == ST_ADDR) || (st_q == ST_DATA);

  always_comb begin
    byte_ok = 1'b1;
    tx_o    = opc_q;
    if (st_q == ST_ADDR) tx_o = addr_q[{idx_q, 3'b000} +: 8];
    if (st_q == ST_DATA) begin
      byte_ok = read_q ? !rvalid_q : wvalid_i;
      tx_o    = read_q ? 8'h00 : wdata_i;
    end
  end

  assign start_o   = in_byte_st && byte_ok && !issued_q && !busy_i;
  assign wready_o  = (st_q == ST_DATA) && !read_q && !issued_q && !busy_i;
  assign ack_o     = (st_q == ST_ACK);
  assign cfg_err_o = cfg_err_q;
  assign cs_no     = cs_q;
  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      opc_q      <= '0;
      addr_q     <= '0;
      has_addr_q <= 1'b0;
      read_q     <= 1'b0;
      idx_q      <= '0;
      rem_q      <= '0;
      issued_q   <= 1'b0;
      cs_q       <= 1'b1;
      cfg_err_q  <= 1'b0;
      gap_q      <= '0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      cfg_err_q <= 1'b0;
      if (rvalid_q && rready_i) rvalid_q <= 1'b0;
      if (start_o) issued_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (req_i && !cfg_err_q) begin
          if (bad_cfg) begin
            cfg_err_q <= 1'b1;
          end else begin
            opc_q      <= req_opcode_i;
            addr_q     <= req_addr_i;
            has_addr_q <= req_has_addr_i;
            read_q     <= req_read_i;
            idx_q      <= 2'(req_addr_bytes_i - 3'd1);
            rem_q      <= req_count_i;
            issued_q   <= 1'b0;
            cs_q       <= 1'b0;
            st_q       <= ST_OPC;
          end
        end
        ST_OPC: if (done_i) begin
          issued_q <= 1'b0;
          if (has_addr_q)          st_q <= ST_ADDR;
          else if (rem_q != '0)    st_q <= ST_DATA;
          else begin st_q <= ST_GAP; cs_q <= 1'b1; end
        end
        ST_ADDR: if (done_i) begin
          issued_q <= 1'b0;
          if (idx_q != 2'd0)       idx_q <= idx_q - 2'd1;
          else if (rem_q != '0)    st_q <= ST_DATA;
          else begin st_q <= ST_GAP; cs_q <= 1'b1; end
        end
        ST_DATA: if (done_i) begin
          issued_q <= 1'b0;
          if (read_q) begin
            rdata_q  <= rx_i;
            rvalid_q <= 1'b1;
          end
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin st_q <= ST_GAP; cs_q <= 1'b1; end
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) begin
            gap_q <= '0;
            st_q  <= ST_ACK;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_ACK:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // checker-only count of cycles with chip select high
  logic [GW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hi_cnt_q <= GW'(GAP_CYC);
    else if (!cs_q)                     hi_cnt_q <= '0;
    else if (hi_cnt_q != GW'(GAP_CYC))  hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_cs_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt_q >= GW'(GAP_CYC)));
  assert_cfg_no_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (cs_no && $past(cs_no)));
  assert_cfg_no_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !ack_o);
  assert_ack_cs_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> cs_no);
  assert_ack_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_wready_in_frame_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> !cs_no);
  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [7:0]       req_opcode_i,
  input  logic             req_has_addr_i,
  input  logic [2:0]       req_addr_bytes_i,
  input  logic [31:0]      req_addr_i,
  input  logic             req_read_i,
  input  logic [CNT_W-1:0] req_count_i,
  output logic             ack_o,
  output logic             cfg_err_o,
  input  logic [7:0]       wdata_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  input  logic             rready_i,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             cs_no
);
  localparam int unsigned GAP_CYC = 4 * HALF_DIV;

  logic       busy, done, tick, start;
  logic [7:0] rx, tx;

  spi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .tick_o(tick)
  );

  spi_byte_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .tx_i   (tx),
    .tick_i (tick),
    .miso_i (miso_i),
    .busy_o (busy),
    .done_o (done),
    .rx_o   (rx),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
  );

  spi_frame_ctrl #(.CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_i           (req_i),
    .req_opcode_i    (req_opcode_i),
    .req_has_addr_i  (req_has_addr_i),
    .req_addr_bytes_i(req_addr_bytes_i),
    .req_addr_i      (req_addr_i),
    .req_read_i      (req_read_i),
    .req_count_i     (req_count_i),
    .ack_o           (ack_o),
    .cfg_err_o       (cfg_err_o),
    .wdata_i         (wdata_i),
    .wvalid_i        (wvalid_i),
    .wready_o        (wready_o),
    .rdata_o         (rdata_o),
    .rvalid_o        (rvalid_o),
    .rready_i        (rready_i),
    .busy_i          (busy),
    .done_i          (done),
    .rx_i            (rx),
    .start_o         (start),
    .tx_o            (tx),
    .cs_no           (cs_no)
  );

  assert_sclk_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  assert_mosi_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
endmodule

// File: tb/spi_frame_engine_tb.sv
module spi_frame_engine_tb;
  localparam int unsigned HALF_DIV = 2;
  localparam int unsigned CNT_W    = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, req_has_addr_i = 0, req_read_i = 0;
  logic [7:0] req_opcode_i = 0;
  logic [2:0] req_addr_bytes_i = 0;
  logic [31:0] req_addr_i = 0;
  logic [CNT_W-1:0] req_count_i = 0;
  logic ack_o, cfg_err_o, wready_o, rvalid_o, sclk_o, mosi_o, cs_no;
  logic [7:0] wdata_i = 0, rdata_o;
  logic wvalid_i = 0, rready_i = 0, miso_i = 0;

  spi_frame_engine #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0, cyc = 0, nframes = 0, gap_cnt = 1000;
  bit stall = 0, wpop = 0, prev_sclk = 0, prev_mosi = 0, prev_cs = 1;
  logic [7:0] exp_q[$], got_q[$], wq[$], rq[$];
  logic [7:0] gbits = 0;
  int gcnt = 0, cur_f = 0, sbyte = 0, sbit = 7;

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] resp(int j, int f);
    return 8'((j * 37 + f * 11 + 92) & 255);
  endfunction

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 200000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got %0d expected below %0d", cyc, 200000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  // pin monitor and flash model
  always @(negedge clk_i) if (rst_ni) begin
    if (cs_no) check(!sclk_o, "R9 sclk idle", 32'(sclk_o), 0);
    if (sclk_o && prev_sclk) check(mosi_o == prev_mosi, "R9 mosi stable", 32'(mosi_o), 32'(prev_mosi));
    if (!cs_no && prev_cs) begin
      check(gap_cnt >= 4 * HALF_DIV, "R8 cs gap", gap_cnt, 4 * HALF_DIV);
      got_q.delete(); gcnt = 0; cur_f = nframes; nframes++;
      sbyte = 0; sbit = 7; miso_i = resp(0, cur_f)[7];
    end
    if (!cs_no && sclk_o && !prev_sclk) begin
      gbits = {gbits[6:0], mosi_o}; gcnt++;
      if (gcnt == 8) begin got_q.push_back(gbits); gcnt = 0; end
    end
    if (!cs_no && !sclk_o && prev_sclk) begin
      if (sbit == 0) begin sbyte++; sbit = 7; end else sbit--;
      miso_i = resp(sbyte, cur_f)[sbit];
    end
    if (cs_no && !prev_cs) begin
      check(got_q.size() == exp_q.size(), "R1 frame length", got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
        check(got_q[i] == exp_q[i], "R1 R2 frame byte", got_q[i], exp_q[i]);
      check(gcnt == 0, "R1 whole bytes", gcnt, 0);
    end
    gap_cnt = cs_no ? gap_cnt + 1 : 0;
    prev_sclk = sclk_o; prev_mosi = mosi_o; prev_cs = cs_no;
  end

  // write stream source
  always @(negedge clk_i) begin
    if (wpop) void'(wq.pop_front());
    wvalid_i = (wq.size() > 0) && !(stall && (cyc % 5 < 3));
    wdata_i  = (wq.size() > 0) ? wq[0] : 8'h00;
    #1;
    wpop = wvalid_i && wready_o;
  end

  // read stream sink
  always @(negedge clk_i) if (rst_ni) begin
    rready_i = !(stall && (cyc % 5 < 3));
    if (rvalid_o && rready_i) begin
      if (rq.size() == 0) check(0, "R4 extra read byte", rdata_o, 0);
      else check(rdata_o == rq.pop_front(), "R4 read byte", rdata_o, 0);
    end
  end

  task automatic txn(input logic [7:0] opc, input bit has_a, input int ab, input logic [31:0] a,
                     input bit rd, input int cnt, input bit exp_err, input string tag);
    int f0, j;
    @(negedge clk_i);
    f0 = nframes;
    exp_q.delete();
    exp_q.push_back(opc);
    if (has_a && !exp_err) for (int i = ab - 1; i >= 0; i--) exp_q.push_back(a[i*8 +: 8]);
    j = exp_q.size();
    if (!exp_err) for (int k = 0; k < cnt; k++) begin
      if (rd) begin exp_q.push_back(8'h00); rq.push_back(resp(j + k, f0)); end
      else begin
        logic [7:0] w = 8'((k * 29 + opc * 7 + 3) & 255);
        exp_q.push_back(w); wq.push_back(w);
      end
    end
    req_opcode_i = opc; req_has_addr_i = has_a; req_addr_bytes_i = 3'(ab);
    req_addr_i = a; req_read_i = rd; req_count_i = CNT_W'(cnt); req_i = 1;
    do @(negedge clk_i); while (!ack_o && !cfg_err_o);
    req_i = 0;
    check(cfg_err_o == exp_err, {tag, " outcome"}, 32'(cfg_err_o), 32'(exp_err));
    check(cs_no, "R10 ack with cs high", 32'(cs_no), 1);
    check(nframes == f0 + (exp_err ? 0 : 1), {tag, " frame count"}, nframes, f0 + (exp_err ? 0 : 1));
    check(rq.size() == 0, "R4 read count", rq.size(), 0);
    check(wq.size() == 0, "R11 write count", wq.size(), 0);
    @(negedge clk_i);
    check(!ack_o && !cfg_err_o, "R10 R3 single pulse", 32'({ack_o, cfg_err_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(cs_no && !sclk_o && !ack_o && !cfg_err_o && !rvalid_o, "reset state",
          32'({cs_no, sclk_o, ack_o, cfg_err_o, rvalid_o}), 32'h10);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    txn(8'h06, 0, 0, 0, 0, 0, 0, "R6 opcode only");
    txn(8'h05, 0, 0, 0, 1, 1, 0, "R7 status read");
    txn(8'h20, 1, 3, 32'h12345678, 0, 0, 0, "R5 no data write");
    txn(8'h0B, 1, 4, 32'hDEADBEEF, 1, 5, 0, "R2 R4 four byte read");
    txn(8'h02, 1, 1, 32'h000000C3, 0, 3, 0, "R11 write");
    txn(8'h05, 1, 0, 32'h00000011, 1, 2, 1, "R3 zero width");
    txn(8'h05, 1, 5, 32'h00000011, 0, 2, 1, "R3 wide width");
    stall = 1;
    txn(8'h32, 1, 2, 32'h0000A1B2, 0, 4, 0, "R11 stalled write");
    txn(8'h03, 1, 3, 32'h00F0E1D2, 1, 6, 0, "R4 stalled read");
    stall = 0;
    txn(8'h9F, 0, 0, 0, 1, 3, 0, "R7 id read");
    txn(8'hB9, 0, 0, 0, 0, 0, 0, "R6 back to back");
    txn(8'hAB, 0, 0, 0, 0, 0, 0, "R8 back to back");
    repeat (10) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule